// File: doc/BRIEF.md
# Serial Bus Byte Engine with Strong Pull-up

This block sits between a byte-level command source and a single-wire bit slot engine. It takes one byte operation at a time and turns it into eight bit slots, least significant bit first. A write sends the byte. A read issues eight slots that release the line and collects the sampled levels. A touch sends each data bit and replaces it with the level sampled in that slot. When the eighth response arrives, the block presents the assembled byte for one cycle.

Parasitically powered devices on the wire may need extra current right after a write. A caller can leave a one-shot pull-up request holding a duration in milliseconds. The next write byte then turns on the strong pull-up output together with its final bit slot. The output stays on for the requested time after the byte and is then released, and the request is consumed. A millisecond tick is derived from an incoming microsecond tick by a divider.

Top module: `owb_byte_engine`

## Requirements
- R1: A command is accepted in a cycle with cmd_valid and cmd_ready both high, and cmd_ready is high only while the engine is idle. The first slot request follows one cycle after acceptance. Exactly eight slot requests are made, each bit_req_valid pulse lasting one cycle, and the next request follows one cycle after the previous slot's response.
- R2: With cmd_op = 2'b00 (write), slot i carries bit i of cmd_data on bit_req_val, and done_data returns the byte written.
- R3: With cmd_op = 2'b01 (read), every slot carries bit_req_val = 1, and the sample of slot i lands in bit i of done_data.
- R4: With cmd_op = 2'b10 (touch; 2'b11 acts the same), slot i carries bit i of cmd_data, and bit i of done_data is the sample returned for slot i.
- R5: done is a single-cycle pulse in the cycle after the eighth bit response. If no pull-up hold follows, cmd_ready is high in that same cycle.
- R6: A pu_req_valid pulse with a nonzero pu_req_ms leaves a pending pull-up request. On the next write, spu_en is low during slots 0 to 6 and rises in the same cycle as the eighth slot request.
- R7: After such a write, spu_en stays high, counted from the done cycle, for pu_req_ms × US_PER_MS cycles in which us_tick is high. cmd_ready stays low for that time. spu_en then falls and cmd_ready returns.
- R8: The request is one-shot: a second write after the hold gets no pull-up and no hold.
- R9: A pu_req_valid pulse with pu_req_ms = 0 cancels a pending request.
- R10: If pu_hw_en is low when the request is armed, spu_en stays low, but the hold still keeps cmd_ready low for the same duration.
- R11: Read and touch commands never raise spu_en and leave a pending request in place for a later write.
- R12: A pu_req_valid pulse while the pull-up is armed or held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Byte command offered |
| cmd_ready | output | 1 | Engine idle; command accepted when valid is high |
| cmd_op | input | 2 | 00 write, 01 read, 10/11 touch |
| cmd_data | input | 8 | Byte to send (ignored for read) |
| pu_req_valid | input | 1 | Load pull-up request duration |
| pu_req_ms | input | 16 | Requested pull-up duration in ms; 0 cancels |
| pu_hw_en | input | 1 | Strong pull-up hardware present |
| us_tick | input | 1 | One-microsecond timing strobe |
| bit_req_valid | output | 1 | Slot request pulse toward slot engine |
| bit_req_val | output | 1 | Level to write in the slot (1 = release / read) |
| bit_rsp_valid | input | 1 | Slot completed |
| bit_rsp_val | input | 1 | Level sampled in the slot |
| spu_en | output | 1 | Strong pull-up enable |
| done | output | 1 | Result pulse |
| done_data | output | 8 | Assembled byte, valid with done |

## Verification
A wrong bit index or a bad shift step shows up at the ports within one byte: a slot value or a result bit lands in the wrong position, and the bench reads it at the done pulse. An error in arming shows as spu_en rising on a slot other than the eighth, or not rising at all. An error in the hold timer shows as a spu_en or cmd_ready window that differs from pu_req_ms × US_PER_MS by a few cycles. A pending register that is not cleared, or that takes a request it should ignore, only shows on the next write, so every pull-up scenario is followed by a write that must get no pull-up.

// File: rtl/owb_pkg.sv
package owb_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_TOUCH = 2'd2,
    OP_TALT  = 2'd3
  } owb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } owb_state_e;

  // level driven into a slot for a given operation and current data bit
  function automatic logic slot_level(owb_op_e op, logic lsb);
    return (op == OP_READ) ? 1'b1 : lsb;
  endfunction

  // bit kept in the result after a slot completes
  function automatic logic kept_bit(owb_op_e op, logic lsb, logic smp);
    return (op == OP_WRITE) ? lsb : smp;
  endfunction

endpackage

// File: rtl/owb_shift_unit.sv
module owb_shift_unit
  import owb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              step,
  input  owb_op_e           op,
  input  logic              sample,
  output logic              lsb,
  output logic [DATA_W-1:0] next_value
);

  logic [DATA_W-1:0] sh_q;

  assign lsb        = sh_q[0];
  assign next_value = {kept_bit(op, sh_q[0], sample), sh_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= load_data;
    else if (step)  sh_q <= next_value;
  end

endmodule

// File: rtl/owb_hold_timer.sv
module owb_hold_timer #(
  parameter int US_PER_MS = 1000,
  parameter int MS_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] dur_ms,
  input  logic            us_tick,
  output logic            expire
);

  localparam int DIV_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(US_PER_MS - 1);

  logic [DIV_W-1:0] div_q;
  logic [MS_W-1:0]  ms_q;
  logic [MS_W-1:0]  dur_q;
  logic             run_q;
  logic             ms_tick;

  assign ms_tick = run_q && us_tick && (div_q == DIV_LAST);
  assign expire  = ms_tick && (ms_q == dur_q - MS_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      ms_q  <= '0;
      dur_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      div_q <= '0;
      ms_q  <= '0;
      dur_q <= dur_ms;
      run_q <= 1'b1;
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q && us_tick) begin
      if (ms_tick) begin
        div_q <= '0;
        ms_q  <= ms_q + MS_W'(1);
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/owb_pullup_ctl.sv
module owb_pullup_ctl #(
  parameter int MS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [MS_W-1:0] req_ms,
  input  logic            arm_req,
  input  logic            hw_en,
  input  logic            release_evt,
  output logic            arm_evt,
  output logic            armed,
  output logic [MS_W-1:0] arm_ms,
  output logic            spu_en
);

  logic [MS_W-1:0] pend_q;
  logic            hw_q;

  assign arm_evt = arm_req && (pend_q != '0) && !armed;
  assign spu_en  = armed && hw_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     pend_q <= '0;
    else if (release_evt)           pend_q <= '0;
    else if (req_valid && !armed)   pend_q <= req_ms;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      hw_q   <= 1'b0;
      arm_ms <= '0;
    end else if (arm_evt) begin
      armed  <= 1'b1;
      hw_q   <= hw_en;
      arm_ms <= pend_q;
    end else if (release_evt) begin
      armed  <= 1'b0;
      hw_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/owb_byte_engine.sv
module owb_byte_engine
  import owb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MS_W      = 16,
  parameter int US_PER_MS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              pu_req_valid,
  input  logic [MS_W-1:0]   pu_req_ms,
  input  logic              pu_hw_en,
  input  logic              us_tick,
  output logic              bit_req_valid,
  output logic              bit_req_val,
  input  logic              bit_rsp_valid,
  input  logic              bit_rsp_val,
  output logic              spu_en,
  output logic              done,
  output logic [DATA_W-1:0] done_data
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  owb_state_e        st_q;
  owb_op_e           op_q;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q;
  logic [DATA_W-1:0] done_data_q;

  // named internal events
  logic              cmd_accept;
  logic              slot_rsp;
  logic              last_rsp;
  logic              arm_req;
  logic              arm_evt;
  logic              armed;
  logic [MS_W-1:0]   arm_ms;
  logic              hold_start;
  logic              hold_expire;
  logic              st_hold;
  logic              sh_lsb;
  logic [DATA_W-1:0] sh_next;

  assign cmd_ready     = (st_q == ST_IDLE);
  assign cmd_accept    = cmd_valid && cmd_ready;
  assign slot_rsp      = (st_q == ST_WAIT) && bit_rsp_valid;
  assign last_rsp      = slot_rsp && (idx_q == IDX_LAST);
  assign arm_req       = slot_rsp && (idx_q == IDX_LAST - IDX_W'(1)) && (op_q == OP_WRITE);
  assign hold_start    = last_rsp && armed;
  assign st_hold       = (st_q == ST_HOLD);
  assign bit_req_valid = (st_q == ST_ISSUE);
  assign bit_req_val   = slot_level(op_q, sh_lsb);
  assign done          = done_q;
  assign done_data     = done_data_q;

  owb_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd_accept),
    .load_data  (cmd_data),
    .step       (slot_rsp),
    .op         (op_q),
    .sample     (bit_rsp_val),
    .lsb        (sh_lsb),
    .next_value (sh_next)
  );

  owb_pullup_ctl #(.MS_W(MS_W)) u_pullup (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (pu_req_valid),
    .req_ms      (pu_req_ms),
    .arm_req     (arm_req),
    .hw_en       (pu_hw_en),
    .release_evt (hold_expire),
    .arm_evt     (arm_evt),
    .armed       (armed),
    .arm_ms      (arm_ms),
    .spu_en      (spu_en)
  );

  owb_hold_timer #(.US_PER_MS(US_PER_MS), .MS_W(MS_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (hold_start),
    .dur_ms  (arm_ms),
    .us_tick (us_tick),
    .expire  (hold_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_WRITE;
      idx_q       <= '0;
      done_q      <= 1'b0;
      done_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_accept) begin
          op_q  <= owb_op_e'(cmd_op);
          idx_q <= '0;
          st_q  <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (slot_rsp) begin
          if (idx_q == IDX_LAST) begin
            done_q      <= 1'b1;
            done_data_q <= sh_next;
            st_q        <= armed ? ST_HOLD : ST_IDLE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            st_q  <= ST_ISSUE;
          end
        end
        ST_HOLD: if (hold_expire) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/owb_byte_engine_chk.sv
module owb_byte_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       bit_req_valid,
  input logic       bit_req_val,
  input logic       spu_en,
  input logic       done,
  input logic [1:0] op_q,
  input logic       last_rsp,
  input logic       hold_expire
);

  // R1
  slot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req_valid |=> !bit_req_valid);

  // R1
  accept_to_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> bit_req_valid);

  // R3
  read_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req_valid && op_q == 2'd1) |-> bit_req_val);

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_rsp |=> done);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  spu_rise_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_en) |-> bit_req_valid);

  // R7
  spu_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spu_en |-> !cmd_ready);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_expire |=> (cmd_ready && !spu_en));

endmodule

bind owb_byte_engine owb_byte_engine_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .bit_req_valid (bit_req_valid),
  .bit_req_val   (bit_req_val),
  .spu_en        (spu_en),
  .done          (done),
  .op_q          (op_q),
  .last_rsp      (last_rsp),
  .hold_expire   (hold_expire)
);

// File: tb/owb_byte_engine_bench.sv
`timescale 1ns/1ps
module owb_byte_engine_bench;

  localparam int US_PER_MS = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_data = 8'd0;
  logic        pu_req_valid = 1'b0;
  logic [15:0] pu_req_ms = 16'd0;
  logic        pu_hw_en = 1'b1;
  logic        us_tick = 1'b1;
  logic        bit_req_valid;
  logic        bit_req_val;
  logic        bit_rsp_valid = 1'b0;
  logic        bit_rsp_val = 1'b0;
  logic        spu_en;
  logic        done;
  logic [7:0]  done_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] slot_vals;
  logic [7:0] slot_spu;
  logic [7:0] result;

  always #2.5 clk = ~clk;

  owb_byte_engine u_owb_byte_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .pu_req_valid(pu_req_valid),
    .pu_req_ms(pu_req_ms), .pu_hw_en(pu_hw_en), .us_tick(us_tick),
    .bit_req_valid(bit_req_valid), .bit_req_val(bit_req_val),
    .bit_rsp_valid(bit_rsp_valid), .bit_rsp_val(bit_rsp_val),
    .spu_en(spu_en), .done(done), .done_data(done_data)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pu_request(input logic [15:0] ms);
    @(negedge clk);
    pu_req_valid = 1'b1;
    pu_req_ms    = ms;
    @(negedge clk);
    pu_req_valid = 1'b0;
  endtask

  // runs one byte command with a simple slot responder; ends at the done cycle
  task automatic run_cmd(input logic [1:0] op, input logic [7:0] data,
                         input logic [7:0] samples, input int lat);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(bit_req_valid == 1'b1, "R1 first slot one cycle after accept", bit_req_valid, 1);
    for (int i = 0; i < 8; i++) begin
      while (!bit_req_valid) @(negedge clk);
      slot_vals[i] = bit_req_val;
      slot_spu[i]  = spu_en;
      @(negedge clk);
      repeat (lat) @(negedge clk);
      bit_rsp_valid = 1'b1;
      bit_rsp_val   = samples[i];
      @(negedge clk);
      bit_rsp_valid = 1'b0;
      bit_rsp_val   = 1'b0;
    end
    check(done == 1'b1, "R5 done one cycle after last response", done, 1);
    result = done_data;
  endtask

  task automatic count_spu(output int n);
    n = 0;
    while (spu_en) begin n++; @(negedge clk); end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    check(spu_en == 1'b0, "R6 reset spu_en", spu_en, 0);
    check(done == 1'b0, "R5 reset done", done, 0);
    check(bit_req_valid == 1'b0, "R1 reset slot request", bit_req_valid, 0);
  endtask

  task automatic t_write_plain();
    run_cmd(2'b00, 8'hA5, 8'h00, 0);
    check(slot_vals == 8'hA5, "R2 write slot values lsb first", slot_vals, 8'hA5);
    check(result == 8'hA5, "R2 write result byte", result, 8'hA5);
    check(slot_spu == 8'h00, "R6 no pull-up without request", slot_spu, 0);
    check(cmd_ready == 1'b1, "R5 ready in done cycle", cmd_ready, 1);
    @(negedge clk);
    check(done == 1'b0, "R5 done single cycle", done, 0);
  endtask

  task automatic t_read();
    run_cmd(2'b01, 8'h00, 8'h3C, 2);
    check(slot_vals == 8'hFF, "R3 read slots all ones", slot_vals, 8'hFF);
    check(result == 8'h3C, "R3 read sample order", result, 8'h3C);
  endtask

  task automatic t_touch();
    run_cmd(2'b10, 8'h0F, 8'h96, 1);
    check(slot_vals == 8'h0F, "R4 touch slot values", slot_vals, 8'h0F);
    check(result == 8'h96, "R4 touch result", result, 8'h96);
    run_cmd(2'b11, 8'hC3, 8'h5A, 0);
    check(slot_vals == 8'hC3 && result == 8'h5A, "R4 touch alt code", result, 8'h5A);
  endtask

  task automatic t_pullup_write();
    int n;
    pu_request(16'd2);
    run_cmd(2'b00, 8'h81, 8'h00, 1);
    check(slot_spu == 8'h80, "R6 pull-up only on eighth slot", slot_spu, 8'h80);
    check(cmd_ready == 1'b0, "R7 busy during hold", cmd_ready, 0);
    count_spu(n);
    check(n == 2 * US_PER_MS, "R7 hold length", n, 2 * US_PER_MS);
    check(cmd_ready == 1'b1, "R7 ready after release", cmd_ready, 1);
    run_cmd(2'b00, 8'h00, 8'h00, 0);
    check(slot_spu == 8'h00, "R8 one-shot no pull-up on second write", slot_spu, 0);
    check(cmd_ready == 1'b1, "R8 no hold on second write", cmd_ready, 1);
  endtask

  task automatic t_cancel();
    pu_request(16'd3);
    pu_request(16'd0);
    run_cmd(2'b00, 8'h7E, 8'h00, 0);
    check(slot_spu == 8'h00, "R9 cancel removes pull-up", slot_spu, 0);
    check(cmd_ready == 1'b1, "R9 cancel removes hold", cmd_ready, 1);
  endtask

  task automatic t_no_hw();
    int n;
    pu_hw_en = 1'b0;
    pu_request(16'd1);
    run_cmd(2'b00, 8'hF0, 8'h00, 0);
    check(slot_spu == 8'h00 && spu_en == 1'b0, "R10 no spu without hardware", slot_spu, 0);
    count_busy(n);
    check(n == US_PER_MS, "R10 wait still applied", n, US_PER_MS);
    pu_hw_en = 1'b1;
  endtask

  task automatic t_read_touch_keep();
    int n;
    pu_request(16'd1);
    run_cmd(2'b01, 8'h00, 8'hE1, 0);
    check(slot_spu == 8'h00 && cmd_ready == 1'b1, "R11 read gets no pull-up", slot_spu, 0);
    run_cmd(2'b10, 8'h55, 8'h55, 0);
    check(slot_spu == 8'h00 && cmd_ready == 1'b1, "R11 touch gets no pull-up", slot_spu, 0);
    run_cmd(2'b00, 8'h12, 8'h00, 0);
    check(slot_spu == 8'h80, "R11 request kept for later write", slot_spu, 8'h80);
    count_spu(n);
    check(n == US_PER_MS, "R11 later write hold length", n, US_PER_MS);
  endtask

  task automatic t_ignore_while_held();
    pu_request(16'd2);
    run_cmd(2'b00, 8'h33, 8'h00, 0);
    pu_request(16'd4);
    while (!cmd_ready) @(negedge clk);
    run_cmd(2'b00, 8'h44, 8'h00, 0);
    check(slot_spu == 8'h00 && cmd_ready == 1'b1, "R12 request during hold ignored", slot_spu, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_plain();
    t_read();
    t_touch();
    t_pullup_write();
    t_cancel();
    t_no_hw();
    t_read_touch_keep();
    t_ignore_while_held();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule